// File: doc/BRIEF.md
# Pipeline Hazard Stall and Flush Controller

This block decides, cycle by cycle, which stages of a five-stage in-order pipeline advance and which hold. The five stages are prefetch, decode, operand read, a split ALU/memory execute stage, and write-back. The block watches three things: the instruction in the operand-read stage, the instruction one step ahead of it in the ALU stage, and the state of the memory unit. When any of these would break register, flag, branch or write-port ordering, it holds the front of the pipeline or the ALU. It also keeps a one-entry record of an outstanding load, so that readers of the load's target wait for its data.

When the write-back stage resolves a redirect (a taken branch, a jump, an interrupt entry or an interrupt return), the block clears the three front stages in that same cycle. It then holds issue out of the operand-read stage for a fixed refill window. Instructions already in the execute stage are never cleared. The register file, the forwarding paths and the bus logic sit outside this block.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: After reset, with no valid operand-read instruction and prefetch ready, all stalls, `flush_front` and `refill_busy` are low, and `dc_fill` is high.
- R2: An operand-read instruction whose operand B is a register plus an immediate stalls the front stages while the valid ALU-stage instruction writes that same register. The same source without an immediate does not stall.
- R3: A valid ALU-stage instruction that may write PC or CC stalls the operand-read instruction behind it, whether or not the write happens.
- R4: An operand-read instruction that reads CC stalls while the valid ALU-stage instruction sets flags. It does not stall when it does not read CC.
- R5: While the memory unit is busy with a load (`mem_is_load`=1), both the ALU stage and the front stages stall. While it is busy with a store, a non-memory instruction issues and the ALU is not held.
- R6: A memory instruction in operand read while the memory unit is busy (of either kind) stalls the front stages.
- R7: Issuing a load (`op_is_mem`=1 and `op_is_load`=1) records `op_dst` as pending. From the next cycle, any operand-read instruction that uses source A or B equal to that register stalls. Instructions with other sources issue. The record clears on the clock edge at the end of the cycle in which `load_done` is high.
- R8: When `load_done` is high in the same cycle as a valid ALU-stage instruction that writes a register, the ALU stage is held, because only one register write happens per clock.
- R9: `redirect` raises `flush_front` in the same cycle and forces the front stage stalls low. `stall_ex` is unaffected.
- R10: `refill_busy` is high for exactly REFILL_CLKS (default 6) cycles, counting from the `redirect` cycle. `op_issue` is low throughout that window.
- R11: `dc_fill` is high only when `pf_ready` is high, decode is not stalled and no redirect is present.
- R12: Whenever the operand-read stage stalls, decode and prefetch stall too. Whenever the ALU stage stalls and no redirect is present, the operand-read stage stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_ready | input | 1 | Prefetch has an instruction to hand to decode |
| op_valid | input | 1 | Operand-read stage holds an instruction |
| op_src_a | input | RW | Source A register number |
| op_use_a | input | 1 | Source A is read |
| op_src_b | input | RW | Source B register number |
| op_use_b | input | 1 | Source B is read |
| op_b_imm | input | 1 | Operand B adds an immediate to source B |
| op_reads_cc | input | 1 | Instruction reads the CC register |
| op_is_mem | input | 1 | Instruction is a memory operation |
| op_is_load | input | 1 | Memory operation is a load |
| op_dst | input | RW | Destination register of the instruction |
| ex_valid | input | 1 | ALU stage holds an instruction |
| ex_wr_en | input | 1 | ALU-stage instruction writes a register |
| ex_wr_reg | input | RW | ALU-stage destination register |
| ex_wr_pccc | input | 1 | ALU-stage instruction may write PC or CC |
| ex_sets_flags | input | 1 | ALU-stage instruction sets flags |
| mem_busy | input | 1 | Memory unit busy |
| mem_is_load | input | 1 | Busy memory operation is a load |
| load_done | input | 1 | Load result is written back this cycle |
| redirect | input | 1 | Write-back resolved a change of flow |
| stall_pf | output | 1 | Hold prefetch |
| stall_dc | output | 1 | Hold decode |
| stall_op | output | 1 | Hold operand read |
| stall_ex | output | 1 | Hold ALU stage |
| flush_front | output | 1 | Clear prefetch, decode and operand read |
| op_issue | output | 1 | Operand-read instruction moves into execute |
| dc_fill | output | 1 | Decode accepts prefetch output |
| refill_busy | output | 1 | Refill window after a redirect |

## Verification
The checker tests every cycle's local rules: the immediate-after-write, PC/CC and flag-read stalls, ALU hold for busy loads and write-port clashes, flush on redirect, the upstream propagation of stalls, and the stall one cycle after a load issues. Rules that depend on history need the bench's scenario sequences. These are the exact six-cycle length of the refill window, the clearing of a pending load only after `load_done`, a non-matching source issuing past a pending load, and a busy store letting ALU work proceed.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

    // Hold requests toward each pipeline stage.
    typedef struct packed {
        logic pf;
        logic dc;
        logic op;
        logic ex;
    } stage_hold_t;

endpackage

// File: rtl/hz_operand_check.sv
module hz_operand_check #(
    parameter int RW = 4
) (
    input  logic          op_valid,
    input  logic [RW-1:0] op_src_a,
    input  logic          op_use_a,
    input  logic [RW-1:0] op_src_b,
    input  logic          op_use_b,
    input  logic          op_b_imm,
    input  logic          op_reads_cc,
    input  logic          ex_valid,
    input  logic          ex_wr_en,
    input  logic [RW-1:0] ex_wr_reg,
    input  logic          ex_wr_pccc,
    input  logic          ex_sets_flags,
    input  logic          ld_pend,
    input  logic [RW-1:0] ld_reg,
    output logic          reg_hazard
);

    logic imm_hz;
    logic flow_hz;
    logic flag_hz;
    logic load_hz;

    always_comb begin
        // Immediate is summed during operand read, so no bypass exists there.
        imm_hz  = op_b_imm && op_use_b && ex_valid && ex_wr_en
                  && (op_src_b == ex_wr_reg);
        // A possible branch holds the follower until write-back settles it.
        flow_hz = ex_valid && ex_wr_pccc;
        // Flags come out of late logic and cannot feed an operand directly.
        flag_hz = op_reads_cc && ex_valid && ex_sets_flags;
        load_hz = ld_pend && ((op_use_a && (op_src_a == ld_reg))
                           || (op_use_b && (op_src_b == ld_reg)));
        reg_hazard = op_valid && (imm_hz || flow_hz || flag_hz || load_hz);
    end

endmodule

// File: rtl/hz_load_track.sv
module hz_load_track #(
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [RW-1:0] set_reg,
    input  logic          clr_en,
    output logic          pend,
    output logic [RW-1:0] pend_reg
);

    typedef struct packed {
        logic          busy;
        logic [RW-1:0] target;
    } track_t;

    track_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_en) begin
            st_d.busy = 1'b0;
        end
        if (set_en) begin
            st_d.busy   = 1'b1;
            st_d.target = set_reg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend     = st_q.busy;
    assign pend_reg = st_q.target;

endmodule

// File: rtl/hz_refill_timer.sv
module hz_refill_timer #(
    parameter int REFILL_CLKS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CNT_W = $clog2(REFILL_CLKS + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(REFILL_CLKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] left;
    } timer_t;

    timer_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.left = RELOAD;
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // The redirect cycle itself counts as the first refill cycle.
    assign busy = start || (st_q.left != '0);

endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
    import hazard_pkg::*;
#(
    parameter int RW          = 4,
    parameter int REFILL_CLKS = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pf_ready,
    input  logic          op_valid,
    input  logic [RW-1:0] op_src_a,
    input  logic          op_use_a,
    input  logic [RW-1:0] op_src_b,
    input  logic          op_use_b,
    input  logic          op_b_imm,
    input  logic          op_reads_cc,
    input  logic          op_is_mem,
    input  logic          op_is_load,
    input  logic [RW-1:0] op_dst,
    input  logic          ex_valid,
    input  logic          ex_wr_en,
    input  logic [RW-1:0] ex_wr_reg,
    input  logic          ex_wr_pccc,
    input  logic          ex_sets_flags,
    input  logic          mem_busy,
    input  logic          mem_is_load,
    input  logic          load_done,
    input  logic          redirect,
    output logic          stall_pf,
    output logic          stall_dc,
    output logic          stall_op,
    output logic          stall_ex,
    output logic          flush_front,
    output logic          op_issue,
    output logic          dc_fill,
    output logic          refill_busy
);

    logic          reg_hazard;
    logic          ld_pend;
    logic [RW-1:0] ld_reg;
    logic          ld_set;
    logic          refill;
    logic          ex_hold;
    logic          mem_block;
    stage_hold_t   hold;

    hz_operand_check #(.RW(RW)) u_opchk (
        .op_valid      (op_valid),
        .op_src_a      (op_src_a),
        .op_use_a      (op_use_a),
        .op_src_b      (op_src_b),
        .op_use_b      (op_use_b),
        .op_b_imm      (op_b_imm),
        .op_reads_cc   (op_reads_cc),
        .ex_valid      (ex_valid),
        .ex_wr_en      (ex_wr_en),
        .ex_wr_reg     (ex_wr_reg),
        .ex_wr_pccc    (ex_wr_pccc),
        .ex_sets_flags (ex_sets_flags),
        .ld_pend       (ld_pend),
        .ld_reg        (ld_reg),
        .reg_hazard    (reg_hazard)
    );

    hz_load_track #(.RW(RW)) u_ldtrk (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (ld_set),
        .set_reg  (op_dst),
        .clr_en   (load_done),
        .pend     (ld_pend),
        .pend_reg (ld_reg)
    );

    hz_refill_timer #(.REFILL_CLKS(REFILL_CLKS)) u_refill (
        .clk   (clk),
        .rst_n (rst_n),
        .start (redirect),
        .busy  (refill)
    );

    always_comb begin
        // Busy load, or a load and an ALU result racing for the one write port.
        ex_hold   = (mem_busy && mem_is_load) || (load_done && ex_valid && ex_wr_en);
        mem_block = op_valid && op_is_mem && mem_busy;
        hold.ex   = ex_hold;
        // Flushed front stages never hold; execute is never flushed.
        hold.op   = !redirect && (reg_hazard || mem_block || ex_hold);
        hold.dc   = hold.op;
        hold.pf   = hold.dc;
    end

    assign stall_pf    = hold.pf;
    assign stall_dc    = hold.dc;
    assign stall_op    = hold.op;
    assign stall_ex    = hold.ex;
    assign flush_front = redirect;
    assign refill_busy = refill;
    assign op_issue    = op_valid && !hold.op && !refill;
    assign dc_fill     = pf_ready && !hold.dc && !redirect;
    assign ld_set      = op_issue && op_is_mem && op_is_load;

endmodule

// File: rtl/pipe_hazard_ctl_chk.sv
module pipe_hazard_ctl_chk #(
    parameter int RW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [RW-1:0] op_src_a,
    input logic          op_use_a,
    input logic [RW-1:0] op_src_b,
    input logic          op_use_b,
    input logic          op_b_imm,
    input logic          op_reads_cc,
    input logic          op_is_mem,
    input logic          op_is_load,
    input logic [RW-1:0] op_dst,
    input logic          ex_valid,
    input logic          ex_wr_en,
    input logic [RW-1:0] ex_wr_reg,
    input logic          ex_wr_pccc,
    input logic          ex_sets_flags,
    input logic          mem_busy,
    input logic          mem_is_load,
    input logic          load_done,
    input logic          redirect,
    input logic          stall_pf,
    input logic          stall_dc,
    input logic          stall_op,
    input logic          stall_ex,
    input logic          flush_front,
    input logic          op_issue,
    input logic          refill_busy
);

    a_r2_imm_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_b_imm && op_use_b && ex_valid && ex_wr_en
         && op_src_b == ex_wr_reg && !redirect) |-> stall_op);

    a_r3_flow_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ex_valid && ex_wr_pccc) |-> !op_issue);

    a_r4_cc_after_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_reads_cc && ex_valid && ex_sets_flags) |-> !op_issue);

    a_r5_busy_load_holds_alu: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_busy && mem_is_load) |-> stall_ex);

    a_r5_busy_store_frees_alu: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_busy && !mem_is_load && !load_done) |-> !stall_ex);

    a_r6_mem_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_is_mem && mem_busy) |-> !op_issue);

    a_r7_load_reader_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (op_issue && op_is_mem && op_is_load) |=>
        (!(op_valid && op_use_a && op_src_a == $past(op_dst) && !redirect) || stall_op));

    a_r8_single_write_port: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done && ex_valid && ex_wr_en) |-> stall_ex);

    a_r9_flush_clears_front: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (flush_front && !stall_op && !stall_pf));

    a_r10_refill_follows: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (refill_busy && !op_issue));

    a_r12_stall_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_op |-> (stall_dc && stall_pf)) and
        ((stall_ex && !redirect) |-> stall_op));

endmodule

bind pipe_hazard_ctl pipe_hazard_ctl_chk #(.RW(RW)) u_chk (.*);

// File: tb/pipe_hazard_ctl_test.sv
`timescale 1ns/100ps
module pipe_hazard_ctl_test;

    localparam int RW = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic pf_ready, op_valid, op_use_a, op_use_b, op_b_imm, op_reads_cc;
    logic op_is_mem, op_is_load, ex_valid, ex_wr_en, ex_wr_pccc, ex_sets_flags;
    logic mem_busy, mem_is_load, load_done, redirect;
    logic [RW-1:0] op_src_a, op_src_b, op_dst, ex_wr_reg;
    logic stall_pf, stall_dc, stall_op, stall_ex, flush_front, op_issue, dc_fill, refill_busy;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // Output order: pf dc op ex flush issue fill refill
    typedef struct {
        string      tag;
        logic [7:0] exp;
    } item_t;
    item_t exp_q[$];

    always #2 clk = ~clk;

    pipe_hazard_ctl #(.RW(RW), .REFILL_CLKS(6)) uut (.*);

    task automatic clr_in();
        pf_ready = 1'b1; op_valid = 1'b0; op_use_a = 1'b0; op_use_b = 1'b0;
        op_b_imm = 1'b0; op_reads_cc = 1'b0; op_is_mem = 1'b0; op_is_load = 1'b0;
        ex_valid = 1'b0; ex_wr_en = 1'b0; ex_wr_pccc = 1'b0; ex_sets_flags = 1'b0;
        mem_busy = 1'b0; mem_is_load = 1'b0; load_done = 1'b0; redirect = 1'b0;
        op_src_a = '0; op_src_b = '0; op_dst = '0; ex_wr_reg = '0;
    endtask

    // Inputs are already driven after a falling edge; settle, queue, wait a cycle.
    task automatic step(string tag, logic [7:0] exp);
        item_t it;
        #1;
        it.tag = tag;
        it.exp = exp;
        exp_q.push_back(it);
        @(negedge clk);
    endtask

    initial begin : monitor
        forever begin
            item_t it;
            logic [7:0] act;
            wait (exp_q.size() != 0);
            it  = exp_q.pop_front();
            act = {stall_pf, stall_dc, stall_op, stall_ex, flush_front, op_issue, dc_fill, refill_busy};
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s: actual=%b expected=%b", it.tag, act, it.exp);
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        clr_in();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step("R1 idle after reset", 8'b0000_0010);

        // R2: register+immediate read behind a write of the same register
        op_valid = 1; op_use_b = 1; op_b_imm = 1; op_src_b = 4'd3;
        ex_valid = 1; ex_wr_en = 1; ex_wr_reg = 4'd3;
        step("R2 imm read after write stalls", 8'b1110_0000);
        op_src_b = 4'd4;
        step("R2 other register issues", 8'b0000_0110);
        op_src_b = 4'd3; op_b_imm = 0;
        step("R2 plain read not stalled", 8'b0000_0110);

        // R3: possible PC/CC write ahead
        clr_in(); op_valid = 1; ex_valid = 1; ex_wr_pccc = 1;
        step("R3 PC/CC writer holds follower", 8'b1110_0000);

        // R4: CC read after flag setter
        clr_in(); op_valid = 1; op_reads_cc = 1; ex_valid = 1; ex_sets_flags = 1;
        step("R4 CC read after flags stalls", 8'b1110_0000);
        op_reads_cc = 0;
        step("R4 non-CC reader issues", 8'b0000_0110);

        // R5 / R6: memory unit busy
        clr_in(); op_valid = 1; mem_busy = 1; mem_is_load = 1;
        step("R5 busy load holds ALU and front", 8'b1111_0000);
        mem_is_load = 0;
        step("R5 busy store lets ALU work go", 8'b0000_0110);
        op_is_mem = 1;
        step("R6 memory op while busy stalls", 8'b1110_0000);

        // R7: pending load scoreboard
        clr_in(); op_valid = 1; op_is_mem = 1; op_is_load = 1; op_dst = 4'd5;
        step("R7 load issues", 8'b0000_0110);
        clr_in(); op_valid = 1; op_use_a = 1; op_src_a = 4'd5;
        step("R7 reader of pending load stalls", 8'b1110_0000);
        op_src_a = 4'd6;
        step("R7 other source issues", 8'b0000_0110);
        op_use_a = 0; op_use_b = 1; op_src_b = 4'd5; load_done = 1;
        step("R7 still pending in done cycle", 8'b1110_0000);
        load_done = 0;
        step("R7 cleared after load_done", 8'b0000_0110);

        // R8 / R12: write port clash
        clr_in(); ex_valid = 1; ex_wr_en = 1; ex_wr_reg = 4'd9; load_done = 1;
        step("R8 ALU held on port clash (R12 chain)", 8'b1111_0000);

        // R9 / R10: redirect and refill window
        op_valid = 1; redirect = 1;
        step("R9 redirect flushes front", 8'b0001_1001);
        clr_in(); op_valid = 1;
        for (int i = 1; i < 6; i++) begin
            step("R10 refill window active", 8'b0000_0011);
        end
        step("R10 refill window over", 8'b0000_0110);

        // R11: prefetch not ready
        clr_in(); pf_ready = 0;
        step("R11 no fill without prefetch", 8'b0000_0000);

        wait (exp_q.size() == 0);
        #1;
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule